// File: doc/BRIEF.md
# I2C Bus Protocol Monitor

This block watches a two-wire I2C bus and never drives it. It samples the clock line and the data line with a fast system clock and decodes what it sees into a stream of events. The bus lines pass through synchronizers first.

The block reports four kinds of event:
- START and STOP conditions.
- The address byte, which is the first frame after each START. The monitor splits it into a 7-bit target address and a direction flag.
- Every data byte that follows the address byte.

Each frame is nine clock pulses: eight data bits, most significant first, then an acknowledge bit. The monitor assembles these pulses and reports the byte together with its acknowledge state.

Each event appears on the outputs as a single-cycle strobe with registered fields. A START or STOP that cuts a frame short is reported with a truncation flag.

A typical use is inside a larger chip. There it logs or triggers on traffic that other masters and targets put on a shared bus.

Top module: `i2c_watch`

## Requirements
- R1: An SDA fall while SCL is high gives a START event, kind code 0.
- R2: An SDA rise while SCL is high gives a STOP event, kind code 1. START and STOP events carry byte, addr, rw and ack all zero.
- R3: The first complete frame after a START gives an ADDR event, kind code 2.
  - evt_byte holds all eight received bits.
  - evt_addr equals evt_byte[7:1].
  - evt_rw equals evt_byte[0], where 1 means read.
- R4: Every later complete frame in the same transfer gives a DATA event, kind code 3. Its evt_rw repeats the direction taken from the last address byte.
- R5: evt_ack is 1 when SDA was low during the ninth SCL pulse of the frame, and 0 when it was high.
- R6: Bits are taken from SDA while SCL is high and are shifted in most significant bit first. SDA changes while SCL is low do not alter the decoded byte.
- R7: A START inside a transfer (a repeated START) restarts bit counting, and the next complete frame is reported as ADDR.
- R8: evt_trunc is 1 on a START or STOP event when between 1 and 8 SCL pulses of the current frame have finished. It is 0 when no pulse has finished, and it is 0 on every ADDR or DATA event.
- R9: evt_valid is high for one cycle per event. All event fields hold their values while evt_valid is low.
- R10: SCL pulses seen before any START, or after a STOP, produce no events.
- R11: After reset, evt_valid and all event fields are 0.
- R12: An ADDR or DATA event is reported after the falling edge of the ninth SCL pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sampled bus clock line |
| sda_in | input | 1 | Sampled bus data line |
| evt_valid | output | 1 | Single-cycle event strobe |
| evt_kind | output | 2 | Event kind: 0 START, 1 STOP, 2 ADDR, 3 DATA |
| evt_byte | output | 8 | Received byte (ADDR and DATA events) |
| evt_addr | output | 7 | Target address (ADDR events) |
| evt_rw | output | 1 | Direction: 1 read, 0 write |
| evt_ack | output | 1 | 1 = acknowledged, 0 = not acknowledged |
| evt_trunc | output | 1 | Frame cut short by this START or STOP |

## Verification
The bench sweeps all 256 address byte values. Each value sets its own acknowledge pattern and data byte, so a swapped bit order, an inverted acknowledge or a stale direction flag shows up as a field mismatch.

The bench also covers several traps:
- The SCL rise that comes just before a STOP or a repeated START. A monitor that counted it as a data bit would raise false truncation flags or emit a bogus frame.
- The SCL fall that comes just after a START. A monitor that counted it would shift every byte by one bit.
- A partial frame ended by STOP and by a repeated START, to show the flag and the return to address decoding.
- Clock pulses on an idle bus, to show that nothing is decoded outside a transfer.

// File: rtl/i2c_watch_pkg.sv
package i2c_watch_pkg;

  typedef enum logic [1:0] {
    EV_START = 2'd0,
    EV_STOP  = 2'd1,
    EV_ADDR  = 2'd2,
    EV_DATA  = 2'd3
  } ev_kind_t;

  // Kind of a completed frame, from whether it is the first after a START.
  function automatic ev_kind_t frame_kind(input logic is_addr);
    return is_addr ? EV_ADDR : EV_DATA;
  endfunction

  // Kind of a bus condition.
  function automatic ev_kind_t cond_kind(input logic is_start);
    return is_start ? EV_START : EV_STOP;
  endfunction

  // Acknowledge decode: a low line on the ninth pulse means accepted.
  function automatic logic ack_of(input logic sda_level);
    return ~sda_level;
  endfunction

endpackage

// File: rtl/i2c_watch_sync.sv
module i2c_watch_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_watch_cond.sv
module i2c_watch_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  logic scl_held_high;
  assign scl_held_high = scl_s & scl_q;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_held_high & sda_q & ~sda_s;
  assign stop_det  = scl_held_high & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_watch_frame.sv
module i2c_watch_frame #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sda_s,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_det,
  input  logic            stop_det,
  output logic            frame_done,
  output logic [BITS-1:0] frame_byte,
  output logic            frame_is_addr,
  output logic            frame_rw,
  output logic            frame_line,
  output logic            partial,
  output logic            in_xfer
);
  localparam int CW = $clog2(BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(BITS);

  logic [CW-1:0]   cnt;
  logic [BITS-1:0] shreg;
  logic            hi_seen, bit_smp, addr_pend, dir_q, xfer_q;

  logic pulse_end;
  assign pulse_end  = xfer_q & scl_fall & hi_seen;
  assign frame_done = pulse_end & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      shreg     <= '0;
      hi_seen   <= 1'b0;
      bit_smp   <= 1'b1;
      addr_pend <= 1'b0;
      dir_q     <= 1'b0;
      xfer_q    <= 1'b0;
    end else if (start_det) begin
      cnt       <= '0;
      hi_seen   <= 1'b0;
      addr_pend <= 1'b1;
      xfer_q    <= 1'b1;
    end else if (stop_det) begin
      cnt       <= '0;
      hi_seen   <= 1'b0;
      addr_pend <= 1'b0;
      xfer_q    <= 1'b0;
    end else if (xfer_q) begin
      if (scl_rise) begin
        bit_smp <= sda_s;
        hi_seen <= 1'b1;
      end else if (pulse_end) begin
        hi_seen <= 1'b0;
        if (cnt == LAST) begin
          cnt       <= '0;
          addr_pend <= 1'b0;
          if (addr_pend) dir_q <= shreg[0];
        end else begin
          shreg <= {shreg[BITS-2:0], bit_smp};
          cnt   <= cnt + 1'b1;
        end
      end
    end
  end

  assign frame_byte    = shreg;
  assign frame_is_addr = addr_pend;
  assign frame_rw      = addr_pend ? shreg[0] : dir_q;
  assign frame_line    = bit_smp;
  assign partial       = (cnt != '0);
  assign in_xfer       = xfer_q;
endmodule

// File: rtl/i2c_watch.sv
module i2c_watch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       evt_valid,
  output logic [1:0] evt_kind,
  output logic [7:0] evt_byte,
  output logic [6:0] evt_addr,
  output logic       evt_rw,
  output logic       evt_ack,
  output logic       evt_trunc
);
  import i2c_watch_pkg::*;

  localparam int BITS = 8;

  logic [1:0] raw_in, sync_out;
  assign raw_in = {scl_in, sda_in};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    i2c_watch_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in[g]), .q(sync_out[g])
    );
  end

  logic scl_s, sda_s;
  assign scl_s = sync_out[1];
  assign sda_s = sync_out[0];

  logic scl_rise, scl_fall, start_det, stop_det;
  i2c_watch_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  logic            frame_done, frame_is_addr, frame_rw, frame_line, partial, in_xfer;
  logic [BITS-1:0] frame_byte;
  i2c_watch_frame #(.BITS(BITS)) u_frame (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .frame_done(frame_done), .frame_byte(frame_byte),
    .frame_is_addr(frame_is_addr), .frame_rw(frame_rw),
    .frame_line(frame_line), .partial(partial), .in_xfer(in_xfer)
  );

  logic cond_hit;
  assign cond_hit = start_det | stop_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_valid <= 1'b0;
      evt_kind  <= 2'd0;
      evt_byte  <= '0;
      evt_addr  <= '0;
      evt_rw    <= 1'b0;
      evt_ack   <= 1'b0;
      evt_trunc <= 1'b0;
    end else if (cond_hit) begin
      evt_valid <= 1'b1;
      evt_kind  <= cond_kind(start_det);
      evt_byte  <= '0;
      evt_addr  <= '0;
      evt_rw    <= 1'b0;
      evt_ack   <= 1'b0;
      evt_trunc <= partial;
    end else if (frame_done) begin
      evt_valid <= 1'b1;
      evt_kind  <= frame_kind(frame_is_addr);
      evt_byte  <= frame_byte;
      evt_addr  <= frame_byte[BITS-1:1];
      evt_rw    <= frame_rw;
      evt_ack   <= ack_of(frame_line);
      evt_trunc <= 1'b0;
    end else begin
      evt_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_watch_chk.sv
module i2c_watch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       evt_valid,
  input logic [1:0] evt_kind,
  input logic [7:0] evt_byte,
  input logic [6:0] evt_addr,
  input logic       evt_rw,
  input logic       evt_ack,
  input logic       evt_trunc,
  input logic       start_det,
  input logic       stop_det,
  input logic       scl_fall,
  input logic       frame_done,
  input logic       in_xfer
);
  // R1
  start_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> evt_valid && evt_kind == 2'd0);

  // R2
  stop_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> evt_valid && evt_kind == 2'd1 && evt_byte == 8'd0 && !evt_ack);

  // R3
  addr_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == 2'd2) |-> evt_addr == evt_byte[7:1] && evt_rw == evt_byte[0]);

  // R8
  frame_no_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind[1]) |-> !evt_trunc);

  // R9
  frame_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind[1]) |=> !evt_valid);

  // R9
  fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |-> $stable({evt_kind, evt_byte, evt_addr, evt_rw, evt_ack, evt_trunc}));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall && !in_xfer) |=> !evt_valid);

  // R12
  frame_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> evt_valid && evt_kind[1]);
endmodule

bind i2c_watch i2c_watch_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_byte(evt_byte),
  .evt_addr(evt_addr), .evt_rw(evt_rw), .evt_ack(evt_ack), .evt_trunc(evt_trunc),
  .start_det(start_det), .stop_det(stop_det), .scl_fall(scl_fall),
  .frame_done(frame_done), .in_xfer(in_xfer)
);

// File: tb/i2c_watch_tb.sv
`timescale 1ns/1ps
module i2c_watch_tb;
  localparam int Q = 3;
  localparam int NMAX = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic       evt_valid, evt_rw, evt_ack, evt_trunc;
  logic [1:0] evt_kind;
  logic [7:0] evt_byte;
  logic [6:0] evt_addr;

  always #4 clk = ~clk;

  i2c_watch u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
    .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_byte(evt_byte),
    .evt_addr(evt_addr), .evt_rw(evt_rw), .evt_ack(evt_ack), .evt_trunc(evt_trunc)
  );

  int checks = 0, fails = 0, gcnt = 0, ecnt = 0, vptr = 0;
  bit done = 0;
  logic [1:0] g_kind[NMAX], e_kind[NMAX];
  logic [7:0] g_byte[NMAX], e_byte[NMAX];
  logic [6:0] g_addr[NMAX];
  logic g_rw[NMAX], g_ack[NMAX], g_tr[NMAX], e_rw[NMAX], e_ack[NMAX], e_tr[NMAX];
  string e_req[NMAX];

  always @(negedge clk) begin
    if (rst_n && evt_valid && gcnt < NMAX) begin
      g_kind[gcnt] = evt_kind; g_byte[gcnt] = evt_byte; g_addr[gcnt] = evt_addr;
      g_rw[gcnt] = evt_rw; g_ack[gcnt] = evt_ack; g_tr[gcnt] = evt_trunc;
      gcnt++;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_ev(input string req, input logic [1:0] k, input logic [7:0] b,
                           input logic rw, input logic ack, input logic tr);
    e_kind[ecnt] = k; e_byte[ecnt] = b; e_rw[ecnt] = rw;
    e_ack[ecnt] = ack; e_tr[ecnt] = tr; e_req[ecnt] = req;
    ecnt++;
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    if (!scl) begin sda = 1'b1; qw(); scl = 1'b1; qw(); end
    sda = 1'b0; qw(); scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda = 1'b0; qw(); scl = 1'b1; qw(); sda = 1'b1; qw();
  endtask

  // Data changes while SCL is low: toggle SDA mid-low to exercise R6.
  task automatic send_bit(input logic b);
    sda = ~b; qw(); sda = b; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
  endtask

  task automatic send_byte(input logic [7:0] v, input logic ackline);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    send_bit(ackline);
  endtask

  task automatic verify();
    repeat (10) @(negedge clk);
    check("R9", "event count", gcnt, ecnt);
    for (int i = vptr; i < ecnt && i < gcnt; i++) begin
      check(e_req[i], "kind", g_kind[i], e_kind[i]);
      check(e_req[i], "byte", g_byte[i], e_byte[i]);
      check(e_req[i], "rw", g_rw[i], e_rw[i]);
      check(e_req[i], "ack", g_ack[i], e_ack[i]);
      check("R8", "trunc", g_tr[i], e_tr[i]);
      if (e_kind[i] == 2'd2) check("R3", "addr", g_addr[i], e_byte[i] >> 1);
    end
    gcnt = ecnt;
    vptr = ecnt;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R11 reset state
    check("R11", "valid in reset", evt_valid, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R11", "valid after reset", evt_valid, 0);
    check("R11", "fields after reset",
          {evt_kind, evt_byte, evt_addr, evt_rw, evt_ack, evt_trunc}, 0);

    // R10 clocks on an idle bus
    scl = 1'b0; qw();
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    sda = 1'b1; qw(); scl = 1'b1; qw();
    verify();

    // R1 R2 R3 R4 R5 R12 plain write with ACKs
    bus_start();                 expect_ev("R1", 2'd0, 8'h00, 0, 0, 0);
    send_byte(8'h54, 1'b0);      expect_ev("R3", 2'd2, 8'h54, 0, 1, 0);
    send_byte(8'hC3, 1'b0);      expect_ev("R4", 2'd3, 8'hC3, 0, 1, 0);
    send_byte(8'h81, 1'b1);      expect_ev("R5", 2'd3, 8'h81, 0, 0, 0);
    bus_stop();                  expect_ev("R2", 2'd1, 8'h00, 0, 0, 0);
    verify();

    // R7 repeated start switching to read
    bus_start();                 expect_ev("R1", 2'd0, 8'h00, 0, 0, 0);
    send_byte(8'h54, 1'b0);      expect_ev("R3", 2'd2, 8'h54, 0, 1, 0);
    send_byte(8'h10, 1'b0);      expect_ev("R4", 2'd3, 8'h10, 0, 1, 0);
    bus_start();                 expect_ev("R7", 2'd0, 8'h00, 0, 0, 0);
    send_byte(8'h55, 1'b0);      expect_ev("R7", 2'd2, 8'h55, 1, 1, 0);
    send_byte(8'hA7, 1'b1);      expect_ev("R4", 2'd3, 8'hA7, 1, 0, 0);
    bus_stop();                  expect_ev("R2", 2'd1, 8'h00, 0, 0, 0);
    verify();

    // R8 truncated by STOP after 3 pulses, and by a repeated START after 5
    bus_start();                 expect_ev("R1", 2'd0, 8'h00, 0, 0, 0);
    send_bit(1); send_bit(0); send_bit(1);
    bus_stop();                  expect_ev("R8", 2'd1, 8'h00, 0, 0, 1);
    bus_start();                 expect_ev("R8", 2'd0, 8'h00, 0, 0, 0);
    for (int i = 0; i < 5; i++) send_bit(i[0]);
    bus_start();                 expect_ev("R8", 2'd0, 8'h00, 0, 0, 1);
    send_byte(8'h3B, 1'b0);      expect_ev("R7", 2'd2, 8'h3B, 1, 1, 0);
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    bus_stop();                  expect_ev("R8", 2'd1, 8'h00, 0, 0, 1);
    verify();

    // R10 clocks after STOP are ignored
    scl = 1'b0; qw();
    send_bit(1'b0); send_bit(1'b1);
    sda = 1'b1; qw(); scl = 1'b1; qw();
    verify();

    // R3 R4 R5 R6 sweep of every address byte
    for (int v = 0; v < 256; v++) begin
      logic [7:0] a, d;
      a = 8'(v);
      d = a ^ 8'h5A;
      bus_start();               expect_ev("R1", 2'd0, 8'h00, 0, 0, 0);
      send_byte(a, a[1]);        expect_ev("R3", 2'd2, a, a[0], ~a[1], 0);
      send_byte(d, a[2]);        expect_ev("R6", 2'd3, d, a[0], ~a[2], 0);
      bus_stop();                expect_ev("R2", 2'd1, 8'h00, 0, 0, 0);
      if (ecnt > NMAX - 8) verify();
    end
    verify();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule